// File: doc/BRIEF.md
# SD Response Error Checker

This block inspects the 32-bit card status returned with a command response and decides in hardware whether the card reported an error. Software then does not have to read and decode the response after every command. The response word arrives already deserialized and CRC-checked. It comes with a one-cycle valid strobe, a check-enable bit and a format select. The format select picks between the memory status layout (R1) and the SDIO status layout (R5).

The block keeps two sticky status bits, set by hardware and cleared by software with write-1-to-clear pulses. The first is a command-done flag. The second is a response-error flag. An interrupt request is raised when any status bit is set and its signal-enable input is high. Software uses automatic checking by setting the check enable together with the completion-suppress input. In that mode the block interrupts only on a detected error and never on a plain completion.

Top module: `sd_resp_err_chk`

## Requirements
- R1: After reset, `done_stat`, `err_stat` and `irq` are all 0.
- R2: With `chk_en`=1 and `fmt_sel`=0, a valid response sets `err_stat` at the next clock edge if any of bits 31, 30, 29, 26, 25, 23, 21, 20 or 19 is 1 (mask 0xE6B80000).
- R3: With `chk_en`=1 and `fmt_sel`=1, a valid response sets `err_stat` at the next clock edge if any of bits 7, 3, 1 or 0 is 1 (mask 0x0000008B).
- R4: Response bits outside the mask of the selected format never set `err_stat`.
- R5: With `chk_en`=0, no response sets `err_stat`.
- R6: The response word is evaluated only in a cycle where `resp_valid`=1. At all other times its value has no effect on either status bit.
- R7: A valid response sets `done_stat` at the next clock edge when `cc_suppress`=0. When `cc_suppress`=1, `done_stat` is not set, whatever the value of `done_ie`.
- R8: A status bit stays 1 until its clear input is pulsed. A clear pulse alone returns it to 0. A set and a clear in the same cycle leave it at 1.
- R9: `irq` equals (`done_stat` AND `done_ie`) OR (`err_stat` AND `err_ie`) in the same cycle, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| resp_valid | input | 1 | One-cycle strobe marking a received response |
| resp_word | input | 32 | Card status bits of the response |
| chk_en | input | 1 | Enable hardware error checking |
| fmt_sel | input | 1 | Status format: 0 memory (R1), 1 SDIO (R5) |
| cc_suppress | input | 1 | 1 = do not raise command-done status |
| done_ie | input | 1 | Signal enable for command-done status |
| err_ie | input | 1 | Signal enable for response-error status |
| done_clr | input | 1 | Write-1-to-clear pulse for command-done status |
| err_clr | input | 1 | Write-1-to-clear pulse for response-error status |
| done_stat | output | 1 | Sticky command-done status |
| err_stat | output | 1 | Sticky response-error status |
| irq | output | 1 | Interrupt request |

## Verification
A wrong mask bit or a wrong format decode shows up at `err_stat` one clock after the response strobe. The bench walks a single set bit through all 32 positions under both formats, with checking on and off, so every mask bit is examined in isolation. A sticky register that drops its value, or lets a clear beat a set, shows at the status outputs on the first edge after the clear pulse. Faults in the interrupt gating show on `irq` in the same cycle, because it has no register of its own.

// File: rtl/sd_rchk_pkg.sv
// Package: shared constants for the response error checker.
// Assumes a 32-bit card status word; the masks follow the memory and SDIO status layouts.
package sd_rchk_pkg;
    localparam int RESP_W  = 32;
    localparam int NUM_SRC = 2;
    localparam int IDX_DONE = 0;
    localparam int IDX_ERR  = 1;

    // Status format select
    typedef enum logic {
        FMT_MEM  = 1'b0,
        FMT_SDIO = 1'b1
    } resp_fmt_e;

    // Error-flag masks per format
    localparam logic [RESP_W-1:0] MEM_ERR_MASK  = 32'hE6B8_0000;
    localparam logic [RESP_W-1:0] SDIO_ERR_MASK = 32'h0000_008B;
endpackage

// File: rtl/sd_rchk_decode.sv
// Module: selects the error mask for the chosen format and reports whether
// any flagged bit of the response is set. Purely combinational.
module sd_rchk_decode
    import sd_rchk_pkg::*;
(
    input  logic [RESP_W-1:0] resp_word,
    input  resp_fmt_e         fmt,
    output logic              hit
);
    logic [RESP_W-1:0] mask;

    // Pick the mask matching the format, then reduce the masked word
    always_comb begin
        unique case (fmt)
            FMT_SDIO: mask = SDIO_ERR_MASK;
            default:  mask = MEM_ERR_MASK;
        endcase
        hit = |(resp_word & mask);
    end
endmodule

// File: rtl/sd_rchk_sticky.sv
// Module: N independent sticky status bits with write-1-to-clear.
// A set and a clear in the same cycle leave the bit set.
module sd_rchk_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold each bit; set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_i[i])
                q[i] <= 1'b1;
            else if (clr_i[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sd_rchk_irq.sv
// Module: OR of the status bits whose signal enable is high.
// Combinational, so the request follows status and enables in the same cycle.
module sd_rchk_irq #(
    parameter int N = 2
) (
    input  logic [N-1:0] stat,
    input  logic [N-1:0] ie,
    output logic         irq
);
    // Gate each source and merge
    always_comb irq = |(stat & ie);
endmodule

// File: rtl/sd_resp_err_chk.sv
// Top: response error checker. Assumes resp_word is stable and CRC-checked
// in the cycle resp_valid is high; resp_word is ignored otherwise.
module sd_resp_err_chk
    import sd_rchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              resp_valid,
    input  logic [RESP_W-1:0] resp_word,
    input  logic              chk_en,
    input  logic              fmt_sel,
    input  logic              cc_suppress,
    input  logic              done_ie,
    input  logic              err_ie,
    input  logic              done_clr,
    input  logic              err_clr,
    output logic              done_stat,
    output logic              err_stat,
    output logic              irq
);
    logic               hit;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] ie_vec;
    logic [NUM_SRC-1:0] stat_vec;
    resp_fmt_e          fmt;

    assign fmt = resp_fmt_e'(fmt_sel);

    sd_rchk_decode u_dec (
        .resp_word (resp_word),
        .fmt       (fmt),
        .hit       (hit)
    );

    // Form set, clear and enable vectors for the status register
    always_comb begin
        set_vec            = '0;
        set_vec[IDX_DONE]  = resp_valid & ~cc_suppress;
        set_vec[IDX_ERR]   = resp_valid & chk_en & hit;
        clr_vec            = '0;
        clr_vec[IDX_DONE]  = done_clr;
        clr_vec[IDX_ERR]   = err_clr;
        ie_vec             = '0;
        ie_vec[IDX_DONE]   = done_ie;
        ie_vec[IDX_ERR]    = err_ie;
    end

    sd_rchk_sticky #(.N(NUM_SRC)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q     (stat_vec)
    );

    sd_rchk_irq #(.N(NUM_SRC)) u_irq (
        .stat (stat_vec),
        .ie   (ie_vec),
        .irq  (irq)
    );

    assign done_stat = stat_vec[IDX_DONE];
    assign err_stat  = stat_vec[IDX_ERR];
endmodule

// File: rtl/sd_resp_err_chk_chk.sv
// Checker: temporal properties on the ports of sd_resp_err_chk.
module sd_resp_err_chk_chk
    import sd_rchk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              resp_valid,
    input logic [RESP_W-1:0] resp_word,
    input logic              chk_en,
    input logic              fmt_sel,
    input logic              cc_suppress,
    input logic              done_ie,
    input logic              err_ie,
    input logic              done_clr,
    input logic              err_clr,
    input logic              done_stat,
    input logic              err_stat,
    input logic              irq
);
    AST_MEM_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && chk_en && !fmt_sel && |(resp_word & MEM_ERR_MASK)) |=> err_stat); // R2
    AST_SDIO_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && chk_en && fmt_sel && |(resp_word & SDIO_ERR_MASK)) |=> err_stat); // R3
    AST_OUTSIDE_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_stat && !(resp_valid && chk_en &&
          |(resp_word & (fmt_sel ? SDIO_ERR_MASK : MEM_ERR_MASK)))) |=> !err_stat); // R4
    AST_NO_ERR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_stat && (!chk_en || !resp_valid)) |=> !err_stat); // R5
    AST_SUPPRESS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_stat && (cc_suppress || !resp_valid)) |=> !done_stat); // R7
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !cc_suppress) |=> done_stat); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stat && !err_clr) |=> err_stat); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_stat && !done_clr) |=> done_stat); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_ie && !err_ie) |-> !irq); // R9
    AST_IRQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_stat && err_ie) |-> irq); // R9
endmodule

bind sd_resp_err_chk sd_resp_err_chk_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .resp_valid  (resp_valid),
    .resp_word   (resp_word),
    .chk_en      (chk_en),
    .fmt_sel     (fmt_sel),
    .cc_suppress (cc_suppress),
    .done_ie     (done_ie),
    .err_ie      (err_ie),
    .done_clr    (done_clr),
    .err_clr     (err_clr),
    .done_stat   (done_stat),
    .err_stat    (err_stat),
    .irq         (irq)
);

// File: tb/sd_resp_err_chk_tb_top.sv
// Bench: sweeps every response bit under both formats and both check settings,
// then exercises suppression, stickiness, clear priority and interrupt gating.
module sd_resp_err_chk_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        resp_valid, chk_en, fmt_sel, cc_suppress;
    logic        done_ie, err_ie, done_clr, err_clr;
    logic [31:0] resp_word;
    logic        done_stat, err_stat, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_resp_err_chk dut_i (
        .clk(clk), .rst_n(rst_n), .resp_valid(resp_valid), .resp_word(resp_word),
        .chk_en(chk_en), .fmt_sel(fmt_sel), .cc_suppress(cc_suppress),
        .done_ie(done_ie), .err_ie(err_ie), .done_clr(done_clr), .err_clr(err_clr),
        .done_stat(done_stat), .err_stat(err_stat), .irq(irq)
    );

    // Error-flag positions computed from the requirement lists
    function automatic logic is_flag(input logic sel, input int b);
        if (sel) return (b == 7) || (b == 3) || (b == 1) || (b == 0);
        return (b == 31) || (b == 30) || (b == 29) || (b == 26) || (b == 25) ||
               (b == 23) || (b == 21) || (b == 20) || (b == 19);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Clear both status bits for one cycle
    task automatic clear_all();
        @(negedge clk);
        done_clr = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0; err_clr = 1'b0;
    endtask

    // Present one valid response, return at the negedge after the update
    task automatic send(input logic [31:0] w, input logic chk, input logic sel,
                        input logic sup);
        @(negedge clk);
        resp_word = w; chk_en = chk; fmt_sel = sel; cc_suppress = sup;
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0; resp_word = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; resp_valid = 1'b0; resp_word = '0; chk_en = 1'b0;
        fmt_sel = 1'b0; cc_suppress = 1'b0; done_ie = 1'b0; err_ie = 1'b0;
        done_clr = 1'b0; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", done_stat, 1'b0);
        check("R1 err", err_stat, 1'b0);
        check("R1 irq", irq, 1'b0);

        // Single-bit sweep: R2 R3 R4 R5 R7
        for (int sel = 0; sel < 2; sel++) begin
            for (int chk = 0; chk < 2; chk++) begin
                for (int b = 0; b < 32; b++) begin
                    clear_all();
                    send(32'h1 << b, chk[0], sel[0], 1'b0);
                    check(sel ? "R3/R4/R5 bit" : "R2/R4/R5 bit", err_stat,
                          chk[0] & is_flag(sel[0], b));
                    check("R7 done set", done_stat, 1'b1);
                end
            end
        end

        // Full-word patterns, expected computed bitwise
        for (int sel = 0; sel < 2; sel++) begin
            for (int p = 0; p < 16; p++) begin
                logic [31:0] w;
                logic e;
                w = 32'h9E37_79B9 * (p + 1);
                w = w ^ (w >> 13);
                e = 1'b0;
                for (int b = 0; b < 32; b++) e = e | (w[b] & is_flag(sel[0], b));
                clear_all();
                send(w, 1'b1, sel[0], 1'b0);
                check("R2/R3 pattern", err_stat, e);
            end
        end

        // R6: word ignored while resp_valid is low
        clear_all();
        @(negedge clk);
        chk_en = 1'b1; fmt_sel = 1'b0; resp_word = 32'hFFFF_FFFF;
        repeat (4) @(negedge clk);
        check("R6 err", err_stat, 1'b0);
        check("R6 done", done_stat, 1'b0);
        fmt_sel = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 err sdio", err_stat, 1'b0);
        resp_word = '0;

        // R7: suppression blocks done status even with signal enable high
        clear_all();
        @(negedge clk); done_ie = 1'b1; err_ie = 1'b1;
        send(32'h8000_0000, 1'b1, 1'b0, 1'b1);
        check("R7 suppressed done", done_stat, 1'b0);
        check("R7 err still set", err_stat, 1'b1);
        check("R9 irq err", irq, 1'b1);
        clear_all();
        send(32'h0, 1'b1, 1'b0, 1'b1);
        check("R7 suppressed clean", done_stat, 1'b0);
        check("R9 irq idle", irq, 1'b0);

        // R8: stickiness across clean responses, clear alone, set beats clear
        send(32'h0000_0001, 1'b1, 1'b1, 1'b0);
        check("R8 set", err_stat, 1'b1);
        send(32'h0, 1'b1, 1'b1, 1'b0);
        check("R8 sticky", err_stat, 1'b1);
        repeat (3) @(negedge clk);
        check("R8 held", err_stat, 1'b1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        check("R8 cleared", err_stat, 1'b0);
        check("R8 done untouched", done_stat, 1'b1);
        @(negedge clk);
        err_clr = 1'b1; done_clr = 1'b1;
        resp_word = 32'h0000_0080; chk_en = 1'b1; fmt_sel = 1'b1;
        cc_suppress = 1'b0; resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0; err_clr = 1'b0; done_clr = 1'b0; resp_word = '0;
        check("R8 err set wins", err_stat, 1'b1);
        check("R8 done set wins", done_stat, 1'b1);

        // R9: all enable and status combinations
        for (int s = 0; s < 4; s++) begin
            clear_all();
            if (s != 0)
                send(s[1] ? 32'h8000_0000 : 32'h0, 1'b1, 1'b0, ~s[0]);
            for (int en = 0; en < 4; en++) begin
                @(negedge clk);
                done_ie = en[0]; err_ie = en[1];
                #1;
                check("R9 irq", irq, (done_stat & en[0]) | (err_stat & en[1]));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule